// File: doc/BRIEF.md
# Timer Interrupt Skip Controller

This block sits between a timer's raw event pulses and the lines that carry them on as interrupts and converter start triggers. It watches one selected timer event, either crest, trough or both. A small counter advances on each occurrence of that event, and the block uses the counter to thin out the traffic. The first occurrence passes. The next N occurrences are held back, where N is the programmed skip count. Then the cycle repeats. While the counter is non-zero, every crest and trough interrupt is withheld.

Converter start triggers can also be thinned. Each trigger line has a bit in a mask. A masked trigger passes only in the timer period that leads up to the next passed event, that is, while the counter equals the skip count. An unmasked trigger always passes. Gating is combinational, so a pulse that passes leaves the block in the same cycle it arrives. The counter is cleared by reset and by any change of the configuration inputs.

Top module: `intr_skip_ctrl`

## Requirements
- R1: With `src_sel_i` = 0 (no counted source), every output equals its input in the same cycle, whatever the skip count and mask.
- R2: The counted source is encoded on `src_sel_i` as follows: 1 is crest or trough, where a crest and a trough in the same cycle count once; 2 is crest only; 3 is trough only. The counter advances only on the selected event.
- R3: While the counter is non-zero, `ovf_o` and `unf_o` stay low. While it is zero, they follow `ovf_i` and `unf_i` in the same cycle.
- R4: With skip count N (0 to 7), a passed counted event is followed by exactly N blocked counted events, and then the next one passes. N = 0 passes every event.
- R5: Bit k of `adc_mask_i` controls trigger k, where bit 0 is trigger A and bit 1 is trigger B. When the bit is 1, trigger k passes only while the counter equals the skip count. When the bit is 0, trigger k always passes.
- R6: When crests are counted, the trough that follows the last blocked crest passes before the next passed crest. When troughs are counted, the passing crest comes before the passing trough.
- R7: When any configuration input differs from its value in the previous cycle, the counter is zero in the next cycle. A source event in the cycle of the change is not counted.
- R8: An asserted `rst_ni` clears the counter, so the first counted event after reset passes.
- R9: No output is ever high unless its corresponding input is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Counted source: 0 none, 1 crest or trough, 2 crest, 3 trough |
| skip_cnt_i | input | 3 | Number of counted events blocked between passed ones |
| adc_mask_i | input | 2 | Per-trigger skip enable (bit 0 = A, bit 1 = B) |
| ovf_i | input | 1 | Raw overflow/crest pulse |
| unf_i | input | 1 | Raw underflow/trough pulse |
| adc_trg_i | input | 2 | Raw converter start pulses (bit 0 = A, bit 1 = B) |
| ovf_o | output | 1 | Gated overflow/crest interrupt |
| unf_o | output | 1 | Gated underflow/trough interrupt |
| adc_trg_o | output | 2 | Gated converter start pulses |

## Verification
The bench builds the block with its default parameters: a 3-bit skip count and two trigger lines. These values put the widest skip of 7 within reach, and the bench walks a full sequence of one pass, seven blocks and a second pass. The vector walk covers each of the four source encodings and masks with one bit set, both bits set and no bits set. It includes the cycle in which the masked triggers open just before a passed event, as well as crest and trough arriving in the same cycle. Directed steps cover gating during reset, a reset in the middle of a skip run, and a configuration change that clears a partly advanced counter.

// File: rtl/isk_pkg.sv
package isk_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_BOTH   = 2'd1,
    SRC_CREST  = 2'd2,
    SRC_TROUGH = 2'd3
  } src_e;
endpackage

// File: rtl/isk_cfg_watch.sv
module isk_cfg_watch #(
  parameter int unsigned CFG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             chg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  assign chg_o = (cfg_i != cfg_q);
endmodule

// File: rtl/isk_src_sel.sv
module isk_src_sel
  import isk_pkg::*;
(
  input  logic [1:0] src_sel_i,
  input  logic       ovf_i,
  input  logic       unf_i,
  output logic       active_o,
  output logic       step_o
);
  src_e src;
  assign src = src_e'(src_sel_i);

  always_comb begin
    active_o = 1'b1;
    step_o   = 1'b0;
    unique case (src)
      SRC_NONE:   active_o = 1'b0;
      SRC_BOTH:   step_o   = ovf_i | unf_i;
      SRC_CREST:  step_o   = ovf_i;
      SRC_TROUGH: step_o   = unf_i;
      default:    active_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/isk_skip_counter.sv
module isk_skip_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             zero_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= (cnt_q >= limit_i) ? '0 : cnt_q + 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == limit_i);
endmodule

// File: rtl/isk_gate.sv
module isk_gate #(
  parameter int unsigned ADC_N = 2
) (
  input  logic             active_i,
  input  logic             zero_i,
  input  logic             last_i,
  input  logic [ADC_N-1:0] adc_mask_i,
  input  logic             ovf_i,
  input  logic             unf_i,
  input  logic [ADC_N-1:0] adc_trg_i,
  output logic             ovf_o,
  output logic             unf_o,
  output logic [ADC_N-1:0] adc_trg_o
);
  logic irq_open;
  assign irq_open = !active_i || zero_i;
  assign ovf_o    = ovf_i & irq_open;
  assign unf_o    = unf_i & irq_open;

  for (genvar k = 0; k < ADC_N; k++) begin : g_adc
    logic open_k;
    assign open_k       = !active_i || !adc_mask_i[k] || last_i;
    assign adc_trg_o[k] = adc_trg_i[k] & open_k;
  end
endmodule

// File: rtl/intr_skip_ctrl.sv
module intr_skip_ctrl #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned ADC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic [CNT_W-1:0] skip_cnt_i,
  input  logic [ADC_N-1:0] adc_mask_i,
  input  logic             ovf_i,
  input  logic             unf_i,
  input  logic [ADC_N-1:0] adc_trg_i,
  output logic             ovf_o,
  output logic             unf_o,
  output logic [ADC_N-1:0] adc_trg_o
);
  localparam int unsigned CFG_W = 2 + CNT_W + ADC_N;

  logic cfg_chg, active, step, zero, last;

  isk_cfg_watch #(.CFG_W(CFG_W)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  ({src_sel_i, skip_cnt_i, adc_mask_i}),
    .chg_o  (cfg_chg)
  );

  isk_src_sel u_src (
    .src_sel_i (src_sel_i),
    .ovf_i     (ovf_i),
    .unf_i     (unf_i),
    .active_o  (active),
    .step_o    (step)
  );

  isk_skip_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (cfg_chg),
    .step_i  (step),
    .limit_i (skip_cnt_i),
    .zero_o  (zero),
    .last_o  (last)
  );

  isk_gate #(.ADC_N(ADC_N)) u_gate (
    .active_i   (active),
    .zero_i     (zero),
    .last_i     (last),
    .adc_mask_i (adc_mask_i),
    .ovf_i      (ovf_i),
    .unf_i      (unf_i),
    .adc_trg_i  (adc_trg_i),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .adc_trg_o  (adc_trg_o)
  );
endmodule

// File: rtl/isk_checker.sv
module isk_checker #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned ADC_N = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       src_sel_i,
  input logic [CNT_W-1:0] skip_cnt_i,
  input logic [ADC_N-1:0] adc_mask_i,
  input logic             ovf_i,
  input logic             unf_i,
  input logic [ADC_N-1:0] adc_trg_i,
  input logic             ovf_o,
  input logic             unf_o,
  input logic [ADC_N-1:0] adc_trg_o
);
  logic [2+CNT_W+ADC_N-1:0] cfg;
  assign cfg = {src_sel_i, skip_cnt_i, adc_mask_i};

  // R1
  a_r1_none_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'd0) |->
      (ovf_o == ovf_i && unf_o == unf_i && adc_trg_o == adc_trg_i));

  // R3 / R4: a passed crest with a non-zero skip blocks the crest right after
  a_r3_block_after_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'd2 && skip_cnt_i != '0 && ovf_o) |=>
      (!ovf_o || src_sel_i == 2'd0));

  // R4: skip count zero with a settled configuration passes everything
  a_r4_zero_skip_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != 2'd0 && skip_cnt_i == '0 && $stable(cfg)) |->
      (ovf_o == ovf_i && unf_o == unf_i && adc_trg_o == adc_trg_i));

  // R7
  a_r7_clear_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg != $past(cfg)) |=> (ovf_o == ovf_i && unf_o == unf_i));

  // R9
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_o & !ovf_i) == 1'b0 && (unf_o & !unf_i) == 1'b0 &&
     (adc_trg_o & ~adc_trg_i) == '0));

  // R5: an unmasked trigger is never withheld
  a_r5_unmasked_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((adc_trg_i & ~adc_mask_i) & ~adc_trg_o) == '0);
endmodule

bind intr_skip_ctrl isk_checker #(.CNT_W(CNT_W), .ADC_N(ADC_N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_sel_i  (src_sel_i),
  .skip_cnt_i (skip_cnt_i),
  .adc_mask_i (adc_mask_i),
  .ovf_i      (ovf_i),
  .unf_i      (unf_i),
  .adc_trg_i  (adc_trg_i),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o),
  .adc_trg_o  (adc_trg_o)
);

// File: tb/tb_intr_skip_ctrl.sv
`timescale 1ns/1ps
module tb_intr_skip_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] src_sel_i = '0;
  logic [2:0] skip_cnt_i = '0;
  logic [1:0] adc_mask_i = '0;
  logic       ovf_i = 1'b0, unf_i = 1'b0;
  logic [1:0] adc_trg_i = '0;
  logic       ovf_o, unf_o;
  logic [1:0] adc_trg_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  intr_skip_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_sel_i(src_sel_i), .skip_cnt_i(skip_cnt_i),
    .adc_mask_i(adc_mask_i), .ovf_i(ovf_i), .unf_i(unf_i), .adc_trg_i(adc_trg_i),
    .ovf_o(ovf_o), .unf_o(unf_o), .adc_trg_o(adc_trg_o)
  );

  // {src, skip, mask(b,a), in(o,u,a,b), exp(o,u,a,b)}
  localparam int NV = 31;
  localparam logic [14:0] VEC [NV] = '{
    {2'd2,3'd2,2'b11,4'b0000,4'b0000},
    {2'd2,3'd2,2'b11,4'b1010,4'b1000},
    {2'd2,3'd2,2'b11,4'b0101,4'b0000},
    {2'd2,3'd2,2'b11,4'b1000,4'b0000},
    {2'd2,3'd2,2'b11,4'b0011,4'b0011},
    {2'd2,3'd2,2'b11,4'b0100,4'b0000},
    {2'd2,3'd2,2'b11,4'b1000,4'b0000},
    {2'd2,3'd2,2'b11,4'b0110,4'b0100},
    {2'd2,3'd2,2'b11,4'b1000,4'b1000},
    {2'd3,3'd1,2'b01,4'b0000,4'b0000},
    {2'd3,3'd1,2'b01,4'b0100,4'b0100},
    {2'd3,3'd1,2'b01,4'b1011,4'b0011},
    {2'd3,3'd1,2'b01,4'b0100,4'b0000},
    {2'd3,3'd1,2'b01,4'b1010,4'b1000},
    {2'd3,3'd1,2'b01,4'b0101,4'b0101},
    {2'd1,3'd1,2'b10,4'b0000,4'b0000},
    {2'd1,3'd1,2'b10,4'b1000,4'b1000},
    {2'd1,3'd1,2'b10,4'b0111,4'b0011},
    {2'd1,3'd1,2'b10,4'b0101,4'b0100},
    {2'd1,3'd1,2'b10,4'b1100,4'b0000},
    {2'd1,3'd1,2'b10,4'b1000,4'b1000},
    {2'd0,3'd5,2'b11,4'b1111,4'b1111},
    {2'd0,3'd5,2'b11,4'b1010,4'b1010},
    {2'd2,3'd0,2'b11,4'b0000,4'b0000},
    {2'd2,3'd0,2'b11,4'b1010,4'b1010},
    {2'd2,3'd0,2'b11,4'b1101,4'b1101},
    {2'd2,3'd3,2'b00,4'b0000,4'b0000},
    {2'd2,3'd3,2'b00,4'b1000,4'b1000},
    {2'd2,3'd3,2'b00,4'b1000,4'b0000},
    {2'd2,3'd4,2'b00,4'b0000,4'b0000},
    {2'd2,3'd4,2'b00,4'b1000,4'b1000}
  };

  function automatic string vec_req(int i);
    if (i <= 8)  return "R2 R3 R5 R6 crest count";
    if (i <= 14) return "R2 R3 R5 R6 trough count";
    if (i <= 20) return "R2 R3 R5 both count";
    if (i <= 22) return "R1 no source";
    if (i <= 25) return "R4 skip zero";
    return "R7 config change clears";
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ovf_o, unf_o, adc_trg_o[0], adc_trg_o[1]};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (o,u,a,b)", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic [2:0] k, input logic [1:0] m,
                       input logic [3:0] ev);
    src_sel_i  = s;
    skip_cnt_i = k;
    adc_mask_i = m;
    ovf_i      = ev[3];
    unf_i      = ev[2];
    adc_trg_i  = {ev[0], ev[1]};
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8: gating in reset sees a cleared counter
    @(negedge clk_i);
    drive(2'd2, 3'd2, 2'b11, 4'b1010);
    #1 check("R8 gating during reset", 4'b1000);
    @(negedge clk_i);
    drive(2'd0, 3'd0, 2'b00, 4'b0000);
    #1 check("R8 reset idle outputs", 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i][14:13], VEC[i][12:10], VEC[i][9:8], VEC[i][7:4]);
      #1 check(vec_req(i), VEC[i][3:0]);
    end

    // R4: widest skip, one pass then seven blocked then a pass
    @(negedge clk_i);
    drive(2'd2, 3'd7, 2'b00, 4'b0000);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk_i);
      drive(2'd2, 3'd7, 2'b00, 4'b1000);
      #1 check("R4 skip seven", (i == 0 || i == 8) ? 4'b1000 : 4'b0000);
    end
    @(negedge clk_i);
    drive(2'd2, 3'd7, 2'b00, 4'b1000);
    #1 check("R4 blocked before reset", 4'b0000);

    // R8: reset mid-run clears the counter
    @(negedge clk_i);
    drive(2'd2, 3'd7, 2'b00, 4'b0000);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(2'd2, 3'd7, 2'b00, 4'b1000);
    #1 check("R8 pass after mid-run reset", 4'b1000);
    @(negedge clk_i);
    drive(2'd2, 3'd7, 2'b00, 4'b0000);
    #1 check("R9 idle after reset", 4'b0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule